// File: doc/BRIEF.md
# Floating-Point Immediate Load Unit

This execution unit carries out two register-immediate floating-point operations without any data-memory access. A 16-bit immediate in bfloat16 layout is gathered from three separate fields of a 32-bit instruction word. The *move* operation takes that immediate as the upper half of a single-precision word and fills the lower half with zeros. It then widens the word to double precision and writes it to the destination register.

The *half* operation is a read-modify-write. The caller supplies the current 64-bit contents of the destination register alongside the instruction. The unit narrows that value to a single-precision image and replaces its low 16 bits with the immediate. It then widens the result back to double precision. Issuing a move and then a half to the same register builds any full single-precision constant in two instructions.

The unit has one register stage. It presents a destination index, write data and a write strobe to a register file that lives outside the block. It never changes any floating-point status.

Top module: `fpimm_unit`

## Requirements
- R1: Bits are numbered with bit 31 as the MSB. The primary opcode is insn[31:26], default 5. The destination index is insn[25:21]. The extended opcode is insn[5:1]: default 3 selects move and default 11 selects half. The immediate is {insn[15:6], insn[20:16], insn[0]}, with insn[15:6] most significant.
- R2: A move writes the double-precision widening of the single word {imm, 16'h0000}. For example, immediate 0x3F80 writes +1.0, 0xBFC0 writes -1.5, 0x3FFF writes +1.9921875 and 0x8000 writes -0.0.
- R3: Widening a normal single copies the sign. It adds 896 to the 8-bit exponent to form the 11-bit exponent and places the 23-bit fraction at the top of the 52-bit fraction. Write data bits [28:0] are therefore always zero.
- R4: A single with an all-ones exponent widens to exponent 0x7FF with its fraction placed at the top, which keeps infinities, the quiet bit and NaN payloads. Immediate 0x7FC0 gives 0x7FF8_0000_0000_0000.
- R5: A single zero widens to a zero of the same sign. A single subnormal is normalised: its leading one becomes implicit and the exponent is 896 minus the count of leading zeros in the 23-bit fraction.
- R6: A half narrows reg_value to a single, replaces bits [15:0] of that single with the immediate, and writes the widening of the result.
- R7: Narrowing has no rounding. Exponent 0x7FF maps to 0xFF. Exponents 897 to 1150 are rebiased by subtracting 896. Exponents 874 to 896 give an exact single subnormal, obtained by shifting {1, top 23 fraction bits} right by 897 minus the exponent. Exponents below 874, including zero, give a zero of the same sign.
- R8: wr_en is high in the cycle after a clock edge that sampled insn_valid high together with a matching primary and extended opcode. It is low in every other cycle.
- R9: A cycle without a matching valid instruction leaves wr_idx and wr_data unchanged.
- R10: While rst_n is low, wr_en, wr_idx and wr_data are all zero.
- R11: A move with immediate 0x3F80 followed by a half with immediate 0x8000, fed the first result as reg_value, writes 0x3FF0_1000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| reg_value | input | 64 | Current contents of the destination register |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | Double-precision write data |

## Verification
The bench applies every possible immediate to the move operation. A design with a misordered immediate gather, a wrong exponent rebias or a missed subnormal normalisation would produce wrong bits for whole classes of immediates, and the sweep would catch it. It then applies every immediate to the half operation, each paired with a different upper half. That upper half takes every value once, including zero, the subnormal, infinity and NaN encodings. A narrowing that rebiased those specials instead of passing them through would corrupt the round trip. Further vectors cover a double below the single-precision range, which must narrow to zero, and the two-step chaining example. Foreign opcodes and an idle strobe are also applied, and must raise no write strobe and leave the held outputs unchanged.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;
    localparam int INSN_W   = 32;
    localparam int IDX_W    = 5;
    localparam int IMM_W    = 16;
    localparam int SP_W     = 32;
    localparam int DP_W     = 64;
    localparam int SP_EXP_W = 8;
    localparam int DP_EXP_W = 11;
    localparam int SP_FRC_W = 23;
    localparam int DP_FRC_W = 52;
    localparam int FRC_PAD  = DP_FRC_W - SP_FRC_W;
    localparam int LZ_W     = 5;
    // exponent bias difference between the two formats
    localparam int BIAS_GAP = 896;
    // smallest double exponent that still maps onto a single subnormal
    localparam int SUB_MIN  = BIAS_GAP - SP_FRC_W + 1;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_MOVE,
        OP_HALF
    } imm_op_e;

    typedef struct packed {
        logic              wr_en;
        logic [IDX_W-1:0]  wr_idx;
        logic [DP_W-1:0]   wr_data;
    } wr_port_s;
endpackage

// File: rtl/fpimm_decode.sv
module fpimm_decode
    import fpimm_pkg::*;
#(
    parameter logic [5:0] OPC     = 6'd5,
    parameter logic [4:0] XO_MOVE = 5'd3,
    parameter logic [4:0] XO_HALF = 5'd11
) (
    input  logic              valid,
    input  logic [INSN_W-1:0] insn,
    output imm_op_e           op,
    output logic [IDX_W-1:0]  idx,
    output logic [IMM_W-1:0]  imm
);
    logic [5:0] opc_f;
    logic [4:0] xo_f;

    always_comb begin
        opc_f = insn[31:26];
        xo_f  = insn[5:1];
        idx   = insn[25:21];
        // high ten bits, then five middle bits, then one low bit
        imm   = {insn[15:6], insn[20:16], insn[0]};
        op    = OP_NONE;
        if (valid && (opc_f == OPC)) begin
            if (xo_f == XO_MOVE) begin
                op = OP_MOVE;
            end else if (xo_f == XO_HALF) begin
                op = OP_HALF;
            end
        end
    end
endmodule

// File: rtl/fpimm_widen.sv
module fpimm_widen
    import fpimm_pkg::*;
(
    input  logic [SP_W-1:0] sp,
    output logic [DP_W-1:0] dp
);
    logic                sgn;
    logic [SP_EXP_W-1:0] e8;
    logic [SP_FRC_W-1:0] f23;
    logic [LZ_W-1:0]     lz;
    logic                seen;
    logic [SP_FRC_W-1:0] f_norm;
    logic [DP_EXP_W-1:0] e_sub;
    logic [DP_EXP_W-1:0] e_norm;

    always_comb begin
        sgn = sp[SP_W-1];
        e8  = sp[SP_W-2 -: SP_EXP_W];
        f23 = sp[SP_FRC_W-1:0];

        // leading-zero count of the fraction for subnormal inputs
        lz   = '0;
        seen = 1'b0;
        for (int i = SP_FRC_W-1; i >= 0; i--) begin
            if (!seen) begin
                if (f23[i]) begin
                    seen = 1'b1;
                end else begin
                    lz = lz + LZ_W'(1);
                end
            end
        end
        f_norm = f23 << (lz + LZ_W'(1));
        e_sub  = DP_EXP_W'(BIAS_GAP) - DP_EXP_W'(lz);
        e_norm = DP_EXP_W'(e8) + DP_EXP_W'(BIAS_GAP);

        if (e8 == '1) begin
            dp = {sgn, {DP_EXP_W{1'b1}}, f23, {FRC_PAD{1'b0}}};
        end else if (e8 == '0) begin
            if (f23 == '0) begin
                dp = {sgn, {(DP_W-1){1'b0}}};
            end else begin
                dp = {sgn, e_sub, f_norm, {FRC_PAD{1'b0}}};
            end
        end else begin
            dp = {sgn, e_norm, f23, {FRC_PAD{1'b0}}};
        end
    end
endmodule

// File: rtl/fpimm_narrow.sv
module fpimm_narrow
    import fpimm_pkg::*;
(
    input  logic [DP_W-1:0] dp,
    output logic [SP_W-1:0] sp
);
    logic                sgn;
    logic [DP_EXP_W-1:0] e11;
    logic [SP_FRC_W-1:0] ftop;
    logic [DP_EXP_W-1:0] e_rb;
    logic [DP_EXP_W-1:0] sh11;
    logic [SP_FRC_W:0]   mant;

    always_comb begin
        sgn  = dp[DP_W-1];
        e11  = dp[DP_W-2 -: DP_EXP_W];
        ftop = dp[DP_FRC_W-1 -: SP_FRC_W];
        e_rb = e11 - DP_EXP_W'(BIAS_GAP);
        sh11 = DP_EXP_W'(BIAS_GAP + 1) - e11;
        mant = {1'b1, ftop} >> sh11[LZ_W-1:0];

        if (e11 == '1) begin
            sp = {sgn, {SP_EXP_W{1'b1}}, ftop};
        end else if (e11 > DP_EXP_W'(BIAS_GAP)) begin
            sp = {sgn, e_rb[SP_EXP_W-1:0], ftop};
        end else if (e11 >= DP_EXP_W'(SUB_MIN)) begin
            sp = {sgn, {SP_EXP_W{1'b0}}, mant[SP_FRC_W-1:0]};
        end else begin
            sp = {sgn, {(SP_W-1){1'b0}}};
        end
    end
endmodule

// File: rtl/fpimm_unit.sv
module fpimm_unit
    import fpimm_pkg::*;
#(
    parameter logic [5:0] OPC     = 6'd5,
    parameter logic [4:0] XO_MOVE = 5'd3,
    parameter logic [4:0] XO_HALF = 5'd11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [DP_W-1:0]   reg_value,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DP_W-1:0]   wr_data
);
    localparam int HALF_W = SP_W - IMM_W;

    imm_op_e          op;
    logic [IDX_W-1:0] dec_idx;
    logic [IMM_W-1:0] dec_imm;
    logic [SP_W-1:0]  sp_old;
    logic [SP_W-1:0]  sp_new;
    logic [DP_W-1:0]  dp_new;
    wr_port_s         port_d;
    wr_port_s         port_q;

    fpimm_decode #(
        .OPC     (OPC),
        .XO_MOVE (XO_MOVE),
        .XO_HALF (XO_HALF)
    ) u_decode (
        .valid (insn_valid),
        .insn  (insn),
        .op    (op),
        .idx   (dec_idx),
        .imm   (dec_imm)
    );

    fpimm_narrow u_narrow (
        .dp (reg_value),
        .sp (sp_old)
    );

    assign sp_new = (op == OP_HALF) ? {sp_old[SP_W-1 -: HALF_W], dec_imm}
                                    : {dec_imm, {HALF_W{1'b0}}};

    fpimm_widen u_widen (
        .sp (sp_new),
        .dp (dp_new)
    );

    always_comb begin
        port_d       = port_q;
        port_d.wr_en = 1'b0;
        if (op != OP_NONE) begin
            port_d.wr_en   = 1'b1;
            port_d.wr_idx  = dec_idx;
            port_d.wr_data = dp_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign wr_en   = port_q.wr_en;
    assign wr_idx  = port_q.wr_idx;
    assign wr_data = port_q.wr_data;
endmodule

// File: rtl/fpimm_checker.sv
module fpimm_checker #(
    parameter logic [5:0] OPC     = 6'd5,
    parameter logic [4:0] XO_MOVE = 5'd3,
    parameter logic [4:0] XO_HALF = 5'd11
) (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_valid,
    input logic [31:0] insn,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic [63:0] wr_data
);
    logic hit_move;
    logic hit_any;
    assign hit_move = insn_valid && (insn[31:26] == OPC) && (insn[5:1] == XO_MOVE);
    assign hit_any  = insn_valid && (insn[31:26] == OPC) &&
                      ((insn[5:1] == XO_MOVE) || (insn[5:1] == XO_HALF));

    a_r8_write_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> wr_en);

    a_r8_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !wr_en);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> ($stable(wr_data) && $stable(wr_idx)));

    a_r1_dest_index: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> (wr_idx == $past(insn[25:21])));

    a_r2_move_sign: assert property (@(posedge clk) disable iff (!rst_n)
        hit_move |=> (wr_data[63] == $past(insn[15])));

    a_r3_low_fraction_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[28:0] == 29'd0));
endmodule

bind fpimm_unit fpimm_checker #(
    .OPC     (OPC),
    .XO_MOVE (XO_MOVE),
    .XO_HALF (XO_HALF)
) u_fpimm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn       (insn),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data)
);

// File: tb/tb_fpimm_unit.sv
`timescale 1ns/1ps
module tb_fpimm_unit;
    localparam logic [5:0] OPC     = 6'd5;
    localparam logic [4:0] XO_MOVE = 5'd3;
    localparam logic [4:0] XO_HALF = 5'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] reg_value = '0;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpimm_unit #(.OPC(OPC), .XO_MOVE(XO_MOVE), .XO_HALF(XO_HALF)) dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .reg_value(reg_value), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] xo,
                                       input logic [4:0] idx, input logic [15:0] imm);
        return {opc, idx, imm[5:1], imm[15:6], xo, imm[0]};
    endfunction

    // arithmetic reference for single -> double
    function automatic logic [63:0] ref_widen(input logic [31:0] s);
        real v;
        int  e;
        int  f;
        e = int'(s[30:23]);
        f = int'(s[22:0]);
        if (e == 255) return {s[31], 11'h7FF, s[22:0], 29'd0};
        if (e == 0 && f == 0) return {s[31], 63'd0};
        if (e == 0) v = real'(f) * (2.0 ** (-149));
        else        v = real'(f + 8388608) * (2.0 ** (e - 150));
        if (s[31]) v = -v;
        return $realtobits(v);
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] ins, input logic [63:0] rv);
        insn_valid = v;
        insn       = ins;
        reg_value  = rv;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        logic [15:0] hi;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 wr_en", {63'd0, wr_en}, 64'd0);
        chk("R10 wr_idx", {59'd0, wr_idx}, 64'd0);
        chk("R10 wr_data", wr_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R4 named constants, R1 index, R8 strobe
        step(1'b1, mk(OPC, XO_MOVE, 5'd4, 16'h3F80), 64'd0);
        chk("R8 strobe", {63'd0, wr_en}, 64'd1);
        chk("R1 index", {59'd0, wr_idx}, 64'd4);
        chk("R2 +1.0", wr_data, 64'h3FF0_0000_0000_0000);
        held = wr_data;
        // R11 chained example
        step(1'b1, mk(OPC, XO_HALF, 5'd4, 16'h8000), held);
        chk("R11 chain", wr_data, 64'h3FF0_1000_0000_0000);
        step(1'b1, mk(OPC, XO_MOVE, 5'd31, 16'hBFC0), 64'd0);
        chk("R2 -1.5", wr_data, 64'hBFF8_0000_0000_0000);
        chk("R1 index 31", {59'd0, wr_idx}, 64'd31);
        step(1'b1, mk(OPC, XO_MOVE, 5'd1, 16'h3FFF), 64'd0);
        chk("R2 1.9921875", wr_data, 64'h3FFF_E000_0000_0000);
        step(1'b1, mk(OPC, XO_MOVE, 5'd1, 16'h8000), 64'd0);
        chk("R5 -0.0", wr_data, 64'h8000_0000_0000_0000);
        step(1'b1, mk(OPC, XO_MOVE, 5'd1, 16'h0000), 64'd0);
        chk("R5 +0.0", wr_data, 64'h0000_0000_0000_0000);
        step(1'b1, mk(OPC, XO_MOVE, 5'd1, 16'h7F80), 64'd0);
        chk("R4 +inf", wr_data, 64'h7FF0_0000_0000_0000);
        step(1'b1, mk(OPC, XO_MOVE, 5'd1, 16'hFF80), 64'd0);
        chk("R4 -inf", wr_data, 64'hFFF0_0000_0000_0000);
        step(1'b1, mk(OPC, XO_MOVE, 5'd2, 16'h7FC0), 64'd0);
        chk("R4 qNaN", wr_data, 64'h7FF8_0000_0000_0000);
        held = wr_data;

        // R9: foreign opcode, foreign extended opcode, idle strobe
        step(1'b1, mk(6'd6, XO_MOVE, 5'd9, 16'h1234), 64'd0);
        chk("R8 foreign opcode strobe", {63'd0, wr_en}, 64'd0);
        chk("R9 foreign opcode data", wr_data, held);
        step(1'b1, mk(OPC, 5'd4, 5'd9, 16'h1234), 64'd0);
        chk("R8 foreign xo strobe", {63'd0, wr_en}, 64'd0);
        chk("R9 foreign xo idx", {59'd0, wr_idx}, 64'd2);
        step(1'b0, mk(OPC, XO_MOVE, 5'd9, 16'h1234), 64'd0);
        chk("R8 idle strobe", {63'd0, wr_en}, 64'd0);
        chk("R9 idle data", wr_data, held);

        // R7: double below single range narrows to signed zero
        step(1'b1, mk(OPC, XO_HALF, 5'd3, 16'h1234), 64'hB000_0000_0000_0000);
        chk("R7 underflow to zero", wr_data, ref_widen(32'h8000_1234));
        // R7: double subnormal-range value (2^-130) narrows exactly
        step(1'b1, mk(OPC, XO_HALF, 5'd3, 16'h0000), {1'b0, 11'd893, 52'd0});
        chk("R7 subnormal narrow", wr_data, ref_widen(32'h0008_0000));

        // R2 R3 R5: full move sweep
        for (int i = 0; i < 65536; i++) begin
            step(1'b1, mk(OPC, XO_MOVE, i[4:0], i[15:0]), 64'd0);
            chk("R2 R3 R5 move sweep", wr_data, ref_widen({i[15:0], 16'h0000}));
        end
        // R6 R7: half sweep, every upper half and every immediate once
        for (int i = 0; i < 65536; i++) begin
            hi = i[15:0] ^ 16'hA5C3;
            step(1'b1, mk(OPC, XO_HALF, i[9:5], i[15:0]), ref_widen({hi, 16'h0000}));
            chk("R6 R7 half sweep", wr_data, ref_widen({hi, i[15:0]}));
        end
        step(1'b0, '0, '0);
        chk("R8 final idle", {63'd0, wr_en}, 64'd0);
        finish_run();
    end
endmodule